// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. It holds an 8-bit accumulator and four status flags (zero, subtract, half-carry, carry). On every clock edge where the strobe is high, it applies the selected operation to the accumulator and an 8-bit operand, then registers the new accumulator and flags. Each operation follows a fixed flag policy.

The same strobe can select a 16-bit stack-pointer-plus-offset add. That operation leaves the accumulator alone and writes its sum to a separate output. Its flags come from the low byte of the add. A running cycle counter adds 4 for each 8-bit operation and 12 for the stack-pointer add. Instruction decode, memory and the register file sit outside this block.

Top module: `acc_alu`

## Requirements
- R1: The flag byte carries zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4; bits 3..0 always read 0. A synchronous reset clears the accumulator, the flags, the stack sum and the cycle counter.
- R2: Code 0 (add) and code 1 (add with carry) write the 8-bit sum of the accumulator and the operand to the accumulator. Code 1 also adds the carry flag. Subtract is cleared. Half-carry is set on a carry out of bit 3, carry on a carry out of bit 7, and zero when the 8-bit result is 0.
- R3: Code 2 (subtract) and code 3 (subtract with borrow) write the accumulator minus the operand. Code 3 also subtracts the carry flag. Subtract is set. Half-carry is set on a borrow from bit 4, carry on a borrow from bit 8, and zero when the 8-bit result is 0.
- R4: Code 7 (compare) sets the flags exactly as code 2 would, but leaves the accumulator unchanged.
- R5: Code 4 (AND) writes the bitwise AND. Half-carry becomes 1, subtract and carry become 0, and zero is set when the result is 0.
- R6: Code 5 (XOR) and code 6 (OR) write their bitwise result. Subtract, half-carry and carry become 0, and zero is set when the result is 0.
- R7: Code 8 (increment) and code 9 (decrement) change the accumulator by one and update zero, subtract and half-carry, but keep the carry flag. Subtract is 0 for code 8 and 1 for code 9. Increment sets half-carry when the low nibble was 0xF. Decrement sets half-carry when the low nibble was 0x0.
- R8: Code 10 (stack add) registers the stack pointer plus the zero-extended operand on the stack sum output. Zero and subtract become 0. Half-carry and carry come from the carry out of bit 3 and bit 7 of the low-byte add. The accumulator is unchanged.
- R9: The cycle counter adds 4 for codes 0..9 and 12 for code 10, wrapping modulo 2^CYC_W.
- R10: With the strobe low, or with codes 11..15, no accumulator, flag, stack sum or counter bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Strobe: apply the operation at this edge |
| op_sel | input | 4 | Operation code |
| operand | input | 8 | Operand or stack offset |
| sp_in | input | 16 | Stack pointer for code 10 |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Flag byte |
| sp_sum_o | output | 16 | Registered stack-pointer sum |
| cyc_o | output | CYC_W | Running cycle count |

## Verification
The bench targets sums that land exactly on 0x100, so zero, half-carry and carry all rise together. A design that tests zero before truncating would miss zero here. It also runs a subtract-with-borrow where the incoming carry alone causes or removes a borrow; dropping the carry-in would give wrong carry and half-carry flags. Compare, increment and decrement are run after carry has been set, so a design that writes the accumulator on compare, or clears carry on increment or decrement, shows a stale value. Stack adds that carry across the byte boundary, unused codes, idle cycles and a counter driven past its wrap point complete the pass.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADC   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SBC   = 4'd3,
        OP_AND   = 4'd4,
        OP_XOR   = 4'd5,
        OP_OR    = 4'd6,
        OP_CMP   = 4'd7,
        OP_INC   = 4'd8,
        OP_DEC   = 4'd9,
        OP_SPADD = 4'd10
    } alu_op_e;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int COST_BYTE = 4;
    localparam int COST_SP   = 12;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              z;
        logic              n;
        logic              h;
        logic              c;
        logic [ADDR_W-1:0] sum;
    } alu_state_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         half,
    output logic         carry
);
    localparam int NIB = 4;

    logic [W:0]   full;
    logic [NIB:0] nib;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            nib  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            nib  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
        end
        res   = full[W-1:0];
        half  = nib[NIB];
        carry = full[W];
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (fn)
            2'd0:    res = a & b;
            2'd1:    res = a ^ b;
            default: res = a | b;
        endcase
    end
endmodule

// File: rtl/acc_alu_spadd.sv
module acc_alu_spadd #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] sp,
    input  logic [DW-1:0] off,
    output logic [AW-1:0] sum,
    output logic          half,
    output logic          carry
);
    localparam int HI_W = AW - DW;

    logic [DW-1:0] lo_res;

    acc_alu_addsub #(.W(DW)) lo_i (
        .a     (sp[DW-1:0]),
        .b     (off),
        .cin   (1'b0),
        .sub   (1'b0),
        .res   (lo_res),
        .half  (half),
        .carry (carry)
    );

    assign sum = {sp[AW-1:DW] + {{(HI_W-1){1'b0}}, carry}, lo_res};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [7:0]        operand,
    input  logic [15:0]       sp_in,
    output logic [7:0]        acc_o,
    output logic [7:0]        flags_o,
    output logic [15:0]       sp_sum_o,
    output logic [CYC_W-1:0]  cyc_o
);
    localparam logic [CYC_W-1:0] STEP_BYTE = CYC_W'(COST_BYTE);
    localparam logic [CYC_W-1:0] STEP_SP   = CYC_W'(COST_SP);

    alu_state_t        st_d, st_q;
    logic [CYC_W-1:0]  cyc_d, cyc_q;

    logic              is_sub, is_step, uses_cin;
    logic [DATA_W-1:0] ar_b, ar_res, lg_res;
    logic              ar_h, ar_c;
    logic [1:0]        lg_fn;
    logic [ADDR_W-1:0] sp_res;
    logic              sp_h, sp_c;

    assign is_step  = (op_sel == OP_INC) || (op_sel == OP_DEC);
    assign uses_cin = (op_sel == OP_ADC) || (op_sel == OP_SBC);
    assign is_sub   = (op_sel == OP_SUB) || (op_sel == OP_SBC) ||
                      (op_sel == OP_CMP) || (op_sel == OP_DEC);
    assign ar_b     = is_step ? DATA_W'(1) : operand;
    assign lg_fn    = (op_sel == OP_AND) ? 2'd0 : (op_sel == OP_XOR) ? 2'd1 : 2'd2;

    acc_alu_addsub #(.W(DATA_W)) arith_i (
        .a     (st_q.acc),
        .b     (ar_b),
        .cin   (uses_cin & st_q.c),
        .sub   (is_sub),
        .res   (ar_res),
        .half  (ar_h),
        .carry (ar_c)
    );

    acc_alu_logic #(.W(DATA_W)) logic_i (
        .a   (st_q.acc),
        .b   (operand),
        .fn  (lg_fn),
        .res (lg_res)
    );

    acc_alu_spadd #(.AW(ADDR_W), .DW(DATA_W)) spadd_i (
        .sp    (sp_in),
        .off   (operand),
        .sum   (sp_res),
        .half  (sp_h),
        .carry (sp_c)
    );

    always_comb begin
        st_d  = st_q;
        cyc_d = cyc_q;
        if (op_valid) begin
            case (op_sel)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                    st_d.acc = ar_res;
                    st_d.z   = (ar_res == '0);
                    st_d.n   = is_sub;
                    st_d.h   = ar_h;
                    st_d.c   = ar_c;
                    cyc_d    = cyc_q + STEP_BYTE;
                end
                OP_CMP: begin
                    st_d.z   = (ar_res == '0);
                    st_d.n   = 1'b1;
                    st_d.h   = ar_h;
                    st_d.c   = ar_c;
                    cyc_d    = cyc_q + STEP_BYTE;
                end
                OP_INC, OP_DEC: begin
                    st_d.acc = ar_res;
                    st_d.z   = (ar_res == '0);
                    st_d.n   = is_sub;
                    st_d.h   = ar_h;
                    cyc_d    = cyc_q + STEP_BYTE;
                end
                OP_AND, OP_XOR, OP_OR: begin
                    st_d.acc = lg_res;
                    st_d.z   = (lg_res == '0);
                    st_d.n   = 1'b0;
                    st_d.h   = (op_sel == OP_AND);
                    st_d.c   = 1'b0;
                    cyc_d    = cyc_q + STEP_BYTE;
                end
                OP_SPADD: begin
                    st_d.sum = sp_res;
                    st_d.z   = 1'b0;
                    st_d.n   = 1'b0;
                    st_d.h   = sp_h;
                    st_d.c   = sp_c;
                    cyc_d    = cyc_q + STEP_SP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cyc_q <= '0;
        end else begin
            st_q  <= st_d;
            cyc_q <= cyc_d;
        end
    end

    assign acc_o    = st_q.acc;
    assign flags_o  = {st_q.z, st_q.n, st_q.h, st_q.c, 4'b0000};
    assign sp_sum_o = st_q.sum;
    assign cyc_o    = cyc_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_sel,
    input logic [7:0]        operand,
    input logic [15:0]       sp_in,
    input logic [7:0]        acc_o,
    input logic [7:0]        flags_o,
    input logic [15:0]       sp_sum_o,
    input logic [CYC_W-1:0]  cyc_o
);
    a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        flags_o[3:0] == 4'b0000);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_o == 8'h00 && flags_o == 8'h00 && sp_sum_o == 16'h0000 && cyc_o == '0));

    a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_CMP) |=> (acc_o == $past(acc_o) && flags_o[6]));

    a_r5_and_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_AND) |=> (flags_o[6:4] == 3'b010));

    a_r6_orxor_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_OR || op_sel == OP_XOR)) |=> (flags_o[6:4] == 3'b000));

    a_r7_step_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_INC || op_sel == OP_DEC)) |=> (flags_o[4] == $past(flags_o[4])));

    a_r8_spadd_flags: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_SPADD) |=> (flags_o[7:6] == 2'b00 && acc_o == $past(acc_o)));

    a_r9_byte_cost: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel <= OP_DEC) |=> (cyc_o == $past(cyc_o) + CYC_W'(COST_BYTE)));

    a_r9_sp_cost: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_SPADD) |=> (cyc_o == $past(cyc_o) + CYC_W'(COST_SP)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_sel > OP_SPADD) |=>
            ($stable(acc_o) && $stable(flags_o) && $stable(sp_sum_o) && $stable(cyc_o)));
endmodule

bind acc_alu acc_alu_chk #(.CYC_W(CYC_W)) chk_i (.*);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
    localparam int TB_CYC_W = 8;

    typedef struct {
        logic [7:0]  acc;
        logic [7:0]  flags;
        logic [15:0] sum;
        logic [7:0]  cyc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [7:0]  operand = 8'd0;
    logic [15:0] sp_in = 16'd0;
    logic [7:0]  acc_o, flags_o;
    logic [15:0] sp_sum_o;
    logic [TB_CYC_W-1:0] cyc_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb_q[$];

    int m_acc = 0, m_z = 0, m_n = 0, m_h = 0, m_c = 0, m_sum = 0, m_cyc = 0;

    always #4 clk = ~clk;

    acc_alu #(.CYC_W(TB_CYC_W)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .operand(operand), .sp_in(sp_in), .acc_o(acc_o), .flags_o(flags_o),
        .sp_sum_o(sp_sum_o), .cyc_o(cyc_o)
    );

    task automatic check(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic logic [7:0] m_flags();
        return {m_z[0], m_n[0], m_h[0], m_c[0], 4'b0000};
    endfunction

    task automatic compare_all(input exp_t e);
        check(e.tag, "acc", int'(acc_o), int'(e.acc));
        check(e.tag, "flags", int'(flags_o), int'(e.flags));
        check(e.tag, "spsum", int'(sp_sum_o), int'(e.sum));
        check(e.tag, "cycles", int'(cyc_o), int'(e.cyc));
    endtask

    function automatic exp_t snapshot(input string tag);
        exp_t e;
        e.acc = 8'(m_acc); e.flags = m_flags(); e.sum = 16'(m_sum);
        e.cyc = 8'(m_cyc); e.tag = tag;
        return e;
    endfunction

    // Reference model, written from the requirements
    task automatic model(input int op, input int b, input int sp);
        int a, ci, r;
        a = m_acc;
        case (op)
            0, 1: begin  // R2
                ci = (op == 1) ? m_c : 0;
                r = a + b + ci;
                m_h = (((a & 15) + (b & 15) + ci) > 15);
                m_c = (r > 255);
                m_acc = r & 255; m_z = (m_acc == 0); m_n = 0;
            end
            2, 3, 7: begin  // R3, R4
                ci = (op == 3) ? m_c : 0;
                r = (a - b - ci) & 255;
                m_h = ((a & 15) < ((b & 15) + ci));
                m_c = (a < (b + ci));
                m_z = (r == 0); m_n = 1;
                if (op != 7) m_acc = r;
            end
            4: begin m_acc = a & b; m_z = (m_acc == 0); m_n = 0; m_h = 1; m_c = 0; end  // R5
            5: begin m_acc = a ^ b; m_z = (m_acc == 0); m_n = 0; m_h = 0; m_c = 0; end  // R6
            6: begin m_acc = a | b; m_z = (m_acc == 0); m_n = 0; m_h = 0; m_c = 0; end  // R6
            8: begin m_h = ((a & 15) == 15); m_acc = (a + 1) & 255; m_z = (m_acc == 0); m_n = 0; end  // R7
            9: begin m_h = ((a & 15) == 0); m_acc = (a - 1) & 255; m_z = (m_acc == 0); m_n = 1; end  // R7
            10: begin  // R8
                m_sum = (sp + b) & 65535;
                m_h = (((sp & 15) + (b & 15)) > 15);
                m_c = (((sp & 255) + b) > 255);
                m_z = 0; m_n = 0;
            end
            default: ;  // R10
        endcase
        if (op <= 9) m_cyc = (m_cyc + 4) & 255;        // R9
        else if (op == 10) m_cyc = (m_cyc + 12) & 255;  // R9
    endtask

    // Driver: entered and left at a falling edge
    task automatic drive(input int op, input int b, input int sp, input string tag);
        model(op, b, sp);
        sb_q.push_back(snapshot(tag));
        op_sel = 4'(op); operand = 8'(b); sp_in = 16'(sp); op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic idle_check(input int op, input int b);
        op_sel = 4'(op); operand = 8'(b); sp_in = 16'hFFFF; op_valid = 1'b0;
        @(negedge clk);
        compare_all(snapshot("R10 idle"));
    endtask

    // Monitor: compares one expected item per strobed edge
    initial begin
        forever begin
            @(posedge clk);
            if (op_valid && !rst) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL scoreboard: actual=empty expected=item");
                end else begin
                    compare_all(sb_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare_all(snapshot("R1 reset"));

        drive(0, 8'hC6 - 8'h8C, 0, "R2 seed");      // acc = 0x3A
        drive(0, 8'hC6, 0, "R2 add to 0x100");       // Z H C
        drive(1, 8'h00, 0, "R2 adc carry in");       // 0x01
        drive(2, 8'h01, 0, "R3 sub to zero");
        drive(2, 8'h01, 0, "R3 sub borrow");         // 0xFF H C N
        drive(3, 8'hFE, 0, "R3 sbc with carry");     // 0x00 Z N
        drive(3, 8'h00, 0, "R3 sbc no carry");
        drive(7, 8'h01, 0, "R4 cmp borrow");         // C=1, acc stays 0
        drive(6, 8'h0F, 0, "R6 or load");
        drive(0, 8'h00, 0, "R2 add zero");
        drive(7, 8'h10, 0, "R4 cmp sets carry");
        drive(8, 0, 0, "R7 inc nibble carry");       // 0x10 H, C kept
        drive(9, 0, 0, "R7 dec nibble borrow");      // 0x0F H N
        drive(4, 8'hF0, 0, "R5 and zero");
        drive(5, 8'h00, 0, "R6 xor zero");
        drive(9, 0, 0, "R7 dec wrap");               // 0xFF
        drive(8, 0, 0, "R7 inc wrap");               // 0x00 Z
        drive(10, 8'h08, 16'h00F8, "R8 sp byte carry");
        drive(10, 8'h01, 16'hFFFF, "R8 sp wrap");
        drive(10, 8'h00, 16'h1234, "R8 sp no carry");
        drive(12, 8'h55, 16'h4321, "R10 unused code");
        drive(15, 8'hAA, 16'h0001, "R10 unused code top");
        idle_check(0, 8'hFF);
        idle_check(10, 8'h80);

        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[15:13] == 3'b000) idle_check(int'(lf[3:0]), int'(lf[11:4]));
            else drive(int'(lf[3:0]) % 12, int'(lf[11:4]), int'({lf[7:0], lf[15:8]}), "R9 mixed");
        end
        repeat (2) @(negedge clk);
        check("R9", "scoreboard drained", sb_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule